// File: doc/BRIEF.md
# Variable-Page Translation Buffer Search

This block holds a small, fully associative set of address translation entries and searches all of them for a virtual address. Each entry has a tag word, a data word and a task identifier. The tag word carries the virtual page number, a valid bit and a three-bit page size code. The page size can be anything from 1 KB to 16 MB. The data word carries the real page number.

A lookup is started by pulsing `req` with a virtual address and the current process identifier. The search over all entries is combinational. It feeds a lowest-index-first priority pick and then one register stage. One cycle after the request, the block presents four results: a hit flag, the index of the winning entry, the real page number, and the page size as both its code and its byte count. These results stay unchanged until the next request.

Entries are loaded one at a time through a write port that addresses an entry by index. Checking access permissions is the job of a separate block and is not done here.

Top module: `vpage_tlb`

## Requirements
- R1: After reset every entry is invalid, and `rsp_valid`, `hit`, `hit_idx`, `real_page`, `size_code` and `size_bytes` are all zero. A lookup made before any entry is loaded misses.
- R2: The page size code sits in tag bits 9:7. A code c means a page of 1024 << (2*c) bytes, so the codes 0 to 7 give 1K, 4K, 16K, 64K, 256K, 1M, 4M and 16M. On a hit, `size_code` is the entry's code and `size_bytes` is that byte count.
- R3: An entry whose tag bit 6 (valid) is clear never matches, whatever its other fields hold.
- R4: The compare mask for an entry is the complement of (page bytes - 1). An entry matches only when the virtual address ANDed with this mask equals the tag word ANDed with the same mask.
- R5: An entry with a nonzero task identifier matches only when the identifier equals `pid`. An entry with task identifier zero matches any `pid`.
- R6: When several entries match, the one with the lowest index wins, and its index is reported on `hit_idx`.
- R7: On a hit, `real_page` equals the entry's data word ANDed with 0xFFFFFC00 (data bits 31:10 are the page number) and then ANDed with the parameter `ADDR_MASK`.
- R8: When no entry matches, the result is a miss: `hit` is 0 and `hit_idx`, `real_page`, `size_code` and `size_bytes` are all 0.
- R9: `rsp_valid` is high exactly in the cycle after a cycle in which `req` was high. The result outputs change only in response to a request and otherwise hold their values.
- R10: When `wr_en` is high, `wr_tag`, `wr_data` and `wr_tid` load into the entry at `wr_idx`. The new contents affect lookups requested from the following cycle on. A lookup requested in the same cycle as the write sees the old contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Load one entry |
| wr_idx | input | IW | Index of the entry to load |
| wr_tag | input | AW | Tag word: page number, size code, valid bit |
| wr_data | input | AW | Data word: real page number |
| wr_tid | input | TIDW | Task identifier of the entry (0 = global) |
| req | input | 1 | Lookup request strobe |
| vaddr | input | AW | Virtual address to translate |
| pid | input | TIDW | Current process identifier |
| rsp_valid | output | 1 | Lookup result presented this cycle |
| hit | output | 1 | A matching entry was found |
| hit_idx | output | IW | Index of the winning entry |
| real_page | output | AW | Masked real page number |
| size_code | output | 3 | Page size code of the winning entry |
| size_bytes | output | AW | Page size in bytes of the winning entry |

## Verification
Damaged state in the entry array shows up at the next lookup that lands in that entry's page range. Such a fault can flip `hit`, move `hit_idx` to a different overlapping entry, or change `real_page` and `size_bytes` one cycle after the request. Because the result registers are compared against a behavioural model on every clock, a stray update between requests is caught in the very cycle it occurs. The stimulus includes overlapping pages of different sizes, both global and private task identifiers, invalid entries, and writes in the same cycle as a lookup. Together these make a wrong mask width, a wrong priority direction or a wrong write timing visible on the first lookup that depends on it.

// File: rtl/vpage_tlb_pkg.sv
package vpage_tlb_pkg;
  localparam int VALID_BIT = 6;
  localparam int CODE_LSB  = 7;
  localparam int CODE_W    = 3;
  localparam int PAGE_LSB  = 10;
  typedef logic [CODE_W-1:0] szc_t;
endpackage

// File: rtl/vpage_tlb_store.sv
module vpage_tlb_store #(
  parameter int N    = 16,
  parameter int AW   = 32,
  parameter int TIDW = 8,
  parameter int IW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [IW-1:0]            wr_idx,
  input  logic [AW-1:0]            wr_tag,
  input  logic [AW-1:0]            wr_data,
  input  logic [TIDW-1:0]          wr_tid,
  output logic [N-1:0][AW-1:0]     tag_q,
  output logic [N-1:0][AW-1:0]     data_q,
  output logic [N-1:0][TIDW-1:0]   tid_q
);

  for (genvar i = 0; i < N; i++) begin : g_ent
    logic            load;
    logic [AW-1:0]   tag_n;
    logic [AW-1:0]   data_n;
    logic [TIDW-1:0] tid_n;

    always_comb begin
      load   = wr_en && (wr_idx == IW'(i));
      tag_n  = load ? wr_tag  : tag_q[i];
      data_n = load ? wr_data : data_q[i];
      tid_n  = load ? wr_tid  : tid_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tag_q[i]  <= '0;
        data_q[i] <= '0;
        tid_q[i]  <= '0;
      end else if (load) begin
        tag_q[i]  <= tag_n;
        data_q[i] <= data_n;
        tid_q[i]  <= tid_n;
      end
    end
  end

  // R10
  entry_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (int'(wr_idx) < N)) |=>
      (tag_q[$past(wr_idx)] == $past(wr_tag)) &&
      (data_q[$past(wr_idx)] == $past(wr_data)) &&
      (tid_q[$past(wr_idx)] == $past(wr_tid)));

endmodule

// File: rtl/vpage_tlb_match.sv
module vpage_tlb_match
  import vpage_tlb_pkg::*;
#(
  parameter int N    = 16,
  parameter int AW   = 32,
  parameter int TIDW = 8
) (
  input  logic [N-1:0][AW-1:0]   tag_q,
  input  logic [N-1:0][TIDW-1:0] tid_q,
  input  logic [AW-1:0]          vaddr,
  input  logic [TIDW-1:0]        pid,
  output logic [N-1:0]           match
);

  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  for (genvar i = 0; i < N; i++) begin : g_cmp
    szc_t          code;
    logic [AW-1:0] bytes;
    logic [AW-1:0] keep;
    logic          page_eq;
    logic          tid_ok;

    always_comb begin
      code    = tag_q[i][CODE_LSB +: CODE_W];
      bytes   = ONE << (PAGE_LSB + 2 * int'(code));
      keep    = ~(bytes - ONE);
      page_eq = ((vaddr ^ tag_q[i]) & keep) == '0;
      tid_ok  = (tid_q[i] == '0) || (tid_q[i] == pid);
      match[i] = tag_q[i][VALID_BIT] && page_eq && tid_ok;
    end
  end

endmodule

// File: rtl/vpage_tlb_pick.sv
module vpage_tlb_pick #(
  parameter int N  = 16,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  match,
  output logic          found,
  output logic [IW-1:0] sel
);

  always_comb begin
    sel   = '0;
    found = |match;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) sel = IW'(i);
    end
  end

  // R6
  pick_is_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> match[sel]);

  // R6
  pick_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match[0] |-> (sel == '0));

endmodule

// File: rtl/vpage_tlb.sv
module vpage_tlb
  import vpage_tlb_pkg::*;
#(
  parameter int          N         = 16,
  parameter int          AW        = 32,
  parameter int          TIDW      = 8,
  parameter logic [31:0] ADDR_MASK = 32'hFFFF_FFFF,
  parameter int          IW        = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  logic [AW-1:0]   wr_tag,
  input  logic [AW-1:0]   wr_data,
  input  logic [TIDW-1:0] wr_tid,
  input  logic            req,
  input  logic [AW-1:0]   vaddr,
  input  logic [TIDW-1:0] pid,
  output logic            rsp_valid,
  output logic            hit,
  output logic [IW-1:0]   hit_idx,
  output logic [AW-1:0]   real_page,
  output logic [2:0]      size_code,
  output logic [AW-1:0]   size_bytes
);

  localparam logic [AW-1:0] ONE      = {{(AW-1){1'b0}}, 1'b1};
  localparam logic [AW-1:0] PG_FIELD = ~((ONE << PAGE_LSB) - ONE);
  localparam logic [AW-1:0] AMASK    = AW'(ADDR_MASK);

  logic [N-1:0][AW-1:0]   tag_q;
  logic [N-1:0][AW-1:0]   data_q;
  logic [N-1:0][TIDW-1:0] tid_q;
  logic [N-1:0]           match;
  logic                   found;
  logic [IW-1:0]          sel;

  vpage_tlb_store #(.N(N), .AW(AW), .TIDW(TIDW), .IW(IW)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_tag(wr_tag), .wr_data(wr_data), .wr_tid(wr_tid),
    .tag_q(tag_q), .data_q(data_q), .tid_q(tid_q)
  );

  vpage_tlb_match #(.N(N), .AW(AW), .TIDW(TIDW)) u_match (
    .tag_q(tag_q), .tid_q(tid_q), .vaddr(vaddr), .pid(pid), .match(match)
  );

  vpage_tlb_pick #(.N(N), .IW(IW)) u_pick (
    .clk(clk), .rst_n(rst_n), .match(match), .found(found), .sel(sel)
  );

  szc_t          sel_code;
  logic [AW-1:0] sel_data;
  logic          rsp_n, hit_n;
  logic [IW-1:0] idx_n;
  logic [AW-1:0] page_n, bytes_n;
  szc_t          code_n;

  always_comb begin
    sel_code = tag_q[sel][CODE_LSB +: CODE_W];
    sel_data = data_q[sel];
    rsp_n    = req;
    hit_n    = hit;
    idx_n    = hit_idx;
    page_n   = real_page;
    code_n   = size_code;
    bytes_n  = size_bytes;
    if (req) begin
      hit_n   = found;
      idx_n   = found ? sel : '0;
      page_n  = found ? (sel_data & PG_FIELD & AMASK) : '0;
      code_n  = found ? sel_code : '0;
      bytes_n = found ? (ONE << (PAGE_LSB + 2 * int'(sel_code))) : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      hit        <= 1'b0;
      hit_idx    <= '0;
      real_page  <= '0;
      size_code  <= '0;
      size_bytes <= '0;
    end else begin
      rsp_valid <= rsp_n;
      if (req) begin
        hit        <= hit_n;
        hit_idx    <= idx_n;
        real_page  <= page_n;
        size_code  <= code_n;
        size_bytes <= bytes_n;
      end
    end
  end

  // R8
  miss_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !hit) |->
      (hit_idx == '0 && real_page == '0 && size_code == '0 && size_bytes == '0));

  // R2
  size_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && hit) |->
      ($countones(size_bytes) == 1 && (size_bytes >> (PAGE_LSB + 2 * int'(size_code))) == ONE));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> ($stable(hit) && $stable(hit_idx) && $stable(real_page) &&
              $stable(size_code) && $stable(size_bytes)));

endmodule

// File: tb/tb_vpage_tlb.sv
module tb_vpage_tlb;
  localparam int          N     = 16;
  localparam int          AW    = 32;
  localparam int          TIDW  = 8;
  localparam int          IW    = 4;
  localparam logic [31:0] AMASK = 32'h0FFF_FFFF;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            wr_en;
  logic [IW-1:0]   wr_idx;
  logic [AW-1:0]   wr_tag, wr_data;
  logic [TIDW-1:0] wr_tid;
  logic            req;
  logic [AW-1:0]   vaddr;
  logic [TIDW-1:0] pid;
  logic            rsp_valid, hit;
  logic [IW-1:0]   hit_idx;
  logic [AW-1:0]   real_page, size_bytes;
  logic [2:0]      size_code;

  always #5 clk = ~clk;

  vpage_tlb #(.N(N), .AW(AW), .TIDW(TIDW), .ADDR_MASK(AMASK)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_tag(wr_tag), .wr_data(wr_data), .wr_tid(wr_tid),
    .req(req), .vaddr(vaddr), .pid(pid), .rsp_valid(rsp_valid), .hit(hit),
    .hit_idx(hit_idx), .real_page(real_page), .size_code(size_code),
    .size_bytes(size_bytes)
  );

  int n_vec = 0;
  int n_bad = 0;
  string scen = "R1";

  logic [31:0] m_tag [N];
  logic [31:0] m_data[N];
  logic [7:0]  m_tid [N];
  logic        e_valid, e_hit;
  int          e_idx;
  logic [31:0] e_page, e_bytes;
  int          e_code;

  task automatic chk(string what, string rq, longint act, longint exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s (scenario %s): got %0h expected %0h", rq, what, scen, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("rsp_valid", "R9", rsp_valid, e_valid);
    chk("hit", scen, hit, e_hit);
    chk("hit_idx", "R6", hit_idx, e_idx);
    chk("real_page", "R7", real_page, e_page);
    chk("size_code", "R2", size_code, e_code);
    chk("size_bytes", "R2", size_bytes, e_bytes);
  endtask

  function automatic logic [31:0] mk_tag(logic [31:0] base, int code, bit v);
    return (base & 32'hFFFF_FC00) | (32'(code) << 7) | (v ? 32'h40 : 32'h0);
  endfunction

  task automatic model_lookup(logic [31:0] va, logic [7:0] p);
    e_hit = 0; e_idx = 0; e_page = 0; e_code = 0; e_bytes = 0;
    for (int i = 0; i < N; i++) begin
      if (m_tag[i][6]) begin
        int          c;
        longint      sz;
        logic [31:0] mk;
        c  = int'(m_tag[i][9:7]);
        sz = 64'd1024 << (2 * c);
        mk = ~(32'(sz) - 32'd1);
        if (((va & mk) == (m_tag[i] & mk)) && (m_tid[i] == 0 || m_tid[i] == p)) begin
          e_hit   = 1;
          e_idx   = i;
          e_page  = m_data[i] & 32'hFFFF_FC00 & AMASK;
          e_code  = c;
          e_bytes = 32'(sz);
          break;
        end
      end
    end
  endtask

  task automatic step(bit do_req, logic [31:0] va, logic [7:0] p,
                      bit do_wr, int wi, logic [31:0] wt, logic [31:0] wd, logic [7:0] wtid);
    @(negedge clk);
    compare_all();
    req = do_req; vaddr = va; pid = p;
    wr_en = do_wr; wr_idx = IW'(wi); wr_tag = wt; wr_data = wd; wr_tid = wtid;
    e_valid = do_req;
    if (do_req) model_lookup(va, p);
    if (do_wr) begin
      m_tag[wi] = wt; m_data[wi] = wd; m_tid[wi] = wtid;
    end
  endtask

  task automatic look(logic [31:0] va, logic [7:0] p);
    step(1, va, p, 0, 0, 0, 0, 0);
  endtask

  task automatic load(int wi, logic [31:0] wt, logic [31:0] wd, logic [7:0] wtid);
    step(0, 0, 0, 1, wi, wt, wd, wtid);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_tag[i] = 0; m_data[i] = 0; m_tid[i] = 0;
    end
    e_valid = 0; e_hit = 0; e_idx = 0; e_page = 0; e_code = 0; e_bytes = 0;
    rst_n = 0; req = 0; vaddr = 0; pid = 0;
    wr_en = 0; wr_idx = 0; wr_tag = 0; wr_data = 0; wr_tid = 0;
    repeat (3) @(posedge clk);
    // R1: outputs are zero during reset
    @(negedge clk);
    compare_all();
    rst_n = 1;
    // R1: lookup before any load misses
    scen = "R1";
    look(32'h0001_0000, 8'd0);
    idle();

    // Load the overlapping set
    load(3,  mk_tag(32'h0001_0000, 1, 1), 32'h0055_5000, 8'd0);   // 4K global
    load(5,  mk_tag(32'h0010_0000, 5, 1), 32'h0900_0000, 8'd7);   // 1M tid 7
    load(2,  mk_tag(32'h0010_4000, 2, 1), 32'h0077_C3FF, 8'd0);   // 16K global inside idx5
    load(8,  mk_tag(32'h0000_2000, 0, 0), 32'h0011_1000, 8'd0);   // invalid 1K
    load(15, mk_tag(32'hA300_0000, 7, 1), 32'hF123_4000, 8'd0);   // 16M
    load(9,  mk_tag(32'h0001_0000, 1, 1), 32'h0066_6000, 8'd0);   // shadowed by idx3

    // R4: masked compare, 4K page, offset bits ignored
    scen = "R4";
    look(32'h0001_0ABC, 8'd1);
    look(32'h0001_1000, 8'd1);
    // R6: overlap 16K idx2 inside 1M idx5, lowest wins; idx3 over idx9
    scen = "R6";
    look(32'h0010_5000, 8'd7);
    look(32'h0001_0004, 8'd0);
    // R5: private task id
    scen = "R5";
    look(32'h0018_0000, 8'd7);
    look(32'h0018_0000, 8'd3);
    look(32'h0010_6000, 8'd3);
    // R3: invalid entry
    scen = "R3";
    look(32'h0000_2004, 8'd0);
    // R7 / R2: large page with address mask
    scen = "R7";
    look(32'hA3FF_FFFC, 8'd0);
    look(32'hA400_0000, 8'd0);
    // R8: miss
    scen = "R8";
    look(32'h7000_0000, 8'd9);
    // R9: idle cycles hold results
    scen = "R9";
    look(32'h0001_0000, 8'd0);
    idle(); idle(); idle();
    // R10: write and lookup in the same cycle sees old contents, then new
    scen = "R10";
    step(1, 32'h0003_0000, 8'd0, 1, 0, mk_tag(32'h0003_0000, 3, 1), 32'h0042_0000, 8'd0);
    look(32'h0003_0000, 8'd0);
    step(1, 32'h0003_0000, 8'd0, 1, 0, mk_tag(32'h0003_0000, 3, 0), 32'h0042_0000, 8'd0);
    look(32'h0003_0000, 8'd0);

    // Mixed traffic
    scen = "R4";
    for (int k = 0; k < 400; k++) begin
      logic [31:0] bases [4];
      logic [31:0] va;
      bases[0] = 32'h0001_0000; bases[1] = 32'h0010_0000;
      bases[2] = 32'hA300_0000; bases[3] = 32'h0003_0000;
      va = bases[$urandom_range(0, 3)] | 32'($urandom_range(0, 32'h000F_FFFF));
      if ($urandom_range(0, 4) == 0)
        step($urandom_range(0, 1) == 1, va, 8'($urandom_range(0, 8)), 1,
             $urandom_range(0, N - 1),
             mk_tag(va, $urandom_range(0, 7), $urandom_range(0, 3) != 0),
             $urandom, 8'($urandom_range(0, 1) == 1 ? $urandom_range(1, 8) : 0));
      else if ($urandom_range(0, 3) == 0)
        idle();
      else
        look(va, 8'($urandom_range(0, 8)));
    end
    idle();
    idle();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule